// File: doc/BRIEF.md
# Bit-Serial SIMD Mesh Array

This block is a small two-dimensional grid of processing elements (4x4 by default), all driven by one control stream on a shared clock. Each element holds a W-bit data register. A central controller accepts one command at a time and applies it to the whole grid. A broadcast command writes a scalar into every enabled element. A reduce command captures the bitwise OR of all element registers into a scalar output. A shift command moves every register one grid position in a chosen compass direction. The shift sends one bit per clock over a 1-bit link between neighbours, and the links wrap around at both edges.

During a shift, each element sends its bits out on a single serial output and takes bits in on a single serial input. The source of each input is picked by the one direction that applies to the whole array. Elements whose enable bit is clear keep their register but still send its bits, least significant first, so their neighbours receive the value as usual. The controller is a three-state machine. `ST_IDLE` accepts commands. `ST_SHIFT` runs the W bit cycles. `ST_DONE` raises the completion pulse. The transitions are: IDLE to SHIFT when a shift is accepted, SHIFT to SHIFT while bits remain, SHIFT to DONE on the last bit, and DONE to IDLE always.

Top module: `simd_mesh_top`

## Requirements
- R1: After reset every element register is zero, `scalar_out` is zero, and `busy` and `done` are low.
- R2: A command with `cmd_op`=1 (broadcast) accepted in idle writes `scalar_in` into every element whose `en_mask` bit is set, visible one cycle later. Elements with a clear bit keep their value.
- R3: A command with `cmd_op`=3 (reduce) accepted in idle sets `scalar_out` to the OR of all element registers, regardless of mask, one cycle later.
- R4: A command with `cmd_op`=2 (shift) moves data one step in direction `cmd_dir`, where 0=N, 1=NE, 2=E, 3=SE, 4=S, 5=SW, 6=W, 7=NW. Row 0 is the top and column 0 is the left, and element index is row*COLS+col. Each enabled element ends holding the prior value of the element one step against the direction.
- R5: Neighbour links wrap around in both rows and columns, forming a torus.
- R6: A shift takes exactly W bit cycles. `done` goes high W cycles after the accepting clock edge, and `busy` stays high from the acceptance until the end of the `done` cycle.
- R7: During a shift, an element whose mask bit (latched at acceptance) is clear keeps its register, and its neighbours still receive its full value.
- R8: Any command presented while `busy` is high is ignored. It changes neither the element registers beyond the running shift nor `scalar_out`.
- R9: `done` is a single-cycle pulse.
- R10: A command with `cmd_op`=0 (no-op), or a cycle without `cmd_valid`, leaves registers and `scalar_out` unchanged.
- R11: `scalar_out` holds its value between reduce commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 no-op, 1 broadcast, 2 shift, 3 reduce |
| cmd_dir | input | 3 | Shift direction code |
| scalar_in | input | W | Broadcast value |
| en_mask | input | ROWS*COLS | Per-element write enable |
| busy | output | 1 | Shift in progress (including done cycle) |
| done | output | 1 | One-cycle shift completion pulse |
| scalar_out | output | W | Last OR-reduction result |
| regs_flat | output | ROWS*COLS*W | All element registers, element i at bits [i*W +: W] |

## Verification
The checker assumes the command inputs carry known values at each rising edge. It also assumes `cmd_valid` is the only qualifier: a stray opcode with `cmd_valid` low is not a command. The bench changes inputs only at falling edges and raises `cmd_valid` for exactly one cycle per command. Apart from the deliberate overlap test, it waits for `done` before issuing the next command. The register-stability property relies on a broadcast being the only idle command that writes registers. For that reason, the stimulus never drives an opcode outside the four defined ones.

// File: rtl/mesh_pkg.sv
package mesh_pkg;

    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_BCAST  = 2'd1,
        OP_SHIFT  = 2'd2,
        OP_REDUCE = 2'd3
    } mesh_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } mesh_state_e;

    localparam int NUM_DIRS = 8;

    // row step of the data movement for each direction code (row 0 on top)
    function automatic int dir_row_step(input int d);
        case (d)
            0, 1, 7: return -1;
            3, 4, 5: return 1;
            default: return 0;
        endcase
    endfunction

    // column step of the data movement for each direction code
    function automatic int dir_col_step(input int d);
        case (d)
            1, 2, 3: return 1;
            5, 6, 7: return -1;
            default: return 0;
        endcase
    endfunction

    // grid index of the element that feeds element (r,c) for direction d
    function automatic int src_index(input int r, input int c, input int d,
                                     input int rows, input int cols);
        int sr;
        int sc;
        sr = (r - dir_row_step(d) + rows) % rows;
        sc = (c - dir_col_step(d) + cols) % cols;
        return sr * cols + sc;
    endfunction

endpackage

// File: rtl/mesh_ctrl.sv
module mesh_ctrl
    import mesh_pkg::*;
#(
    parameter int W    = 8,
    parameter int N    = 16,
    localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [2:0]      cmd_dir,
    input  logic [N-1:0]    en_mask,
    output logic            busy,
    output logic            done,
    output logic            load_stb,
    output logic            reduce_stb,
    output logic            shift_en,
    output logic [IDXW-1:0] bit_idx,
    output logic [2:0]      dir_q,
    output logic [N-1:0]    en_q
);

    localparam logic [IDXW-1:0] LAST_BIT = IDXW'(W - 1);

    mesh_state_e state, state_nx;
    logic [IDXW-1:0] cnt;
    logic            accept;
    logic            start;

    assign accept = cmd_valid && (state == ST_IDLE);
    assign start  = accept && (mesh_op_e'(cmd_op) == OP_SHIFT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SHIFT;
            ST_SHIFT: if (cnt == LAST_BIT) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // bit counter and latched shift setup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            dir_q <= '0;
            en_q  <= '0;
        end else if (start) begin
            cnt   <= '0;
            dir_q <= cmd_dir;
            en_q  <= en_mask;
        end else if (state == ST_SHIFT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        done       = 1'b0;
        shift_en   = 1'b0;
        load_stb   = 1'b0;
        reduce_stb = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load_stb   = accept && (mesh_op_e'(cmd_op) == OP_BCAST);
                reduce_stb = accept && (mesh_op_e'(cmd_op) == OP_REDUCE);
            end
            ST_SHIFT: begin
                busy     = 1'b1;
                shift_en = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign bit_idx = cnt;

endmodule

// File: rtl/mesh_pe.sv
module mesh_pe #(
    parameter int W    = 8,
    localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [W-1:0]    load_val,
    input  logic            shift_en,
    input  logic            en_bit,
    input  logic [IDXW-1:0] bit_idx,
    input  logic            ser_in,
    output logic            ser_out,
    output logic [W-1:0]    value
);

    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_en) begin
            data_q <= load_val;
        end else if (shift_en && en_bit) begin
            data_q <= {ser_in, data_q[W-1:1]};
        end
    end

    // an enabled element presents its moving LSB; a frozen one indexes its
    // held value so the neighbour still receives the bits in LSB-first order
    assign ser_out = en_bit ? data_q[0] : data_q[bit_idx];
    assign value   = data_q;

endmodule

// File: rtl/mesh_reduce.sv
module mesh_reduce #(
    parameter int W = 8,
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture,
    input  logic [N*W-1:0] regs_flat,
    output logic [W-1:0]   result
);

    logic [W-1:0] or_all;

    always_comb begin
        or_all = '0;
        for (int i = 0; i < N; i++) begin
            or_all = or_all | regs_flat[i*W +: W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (capture) begin
            result <= or_all;
        end
    end

endmodule

// File: rtl/simd_mesh_top.sv
module simd_mesh_top
    import mesh_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int W    = 8,
    localparam int N    = ROWS * COLS,
    localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [2:0]     cmd_dir,
    input  logic [W-1:0]   scalar_in,
    input  logic [N-1:0]   en_mask,
    output logic           busy,
    output logic           done,
    output logic [W-1:0]   scalar_out,
    output logic [N*W-1:0] regs_flat
);

    logic                         load_stb;
    logic                         reduce_stb;
    logic                         shift_en;
    logic [IDXW-1:0]              bit_idx;
    logic [2:0]                   dir_q;
    logic [N-1:0]                 en_q;
    logic [N-1:0]                 ser_out;
    logic [N-1:0]                 ser_in;
    logic [N-1:0][NUM_DIRS-1:0]   cand;

    mesh_ctrl #(.W(W), .N(N)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_dir    (cmd_dir),
        .en_mask    (en_mask),
        .busy       (busy),
        .done       (done),
        .load_stb   (load_stb),
        .reduce_stb (reduce_stb),
        .shift_en   (shift_en),
        .bit_idx    (bit_idx),
        .dir_q      (dir_q),
        .en_q       (en_q)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;

            // one candidate source per direction, wrapped on the torus
            for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
                assign cand[IDX][d] = ser_out[src_index(r, c, d, ROWS, COLS)];
            end
            assign ser_in[IDX] = cand[IDX][dir_q];

            mesh_pe #(.W(W)) u_pe (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_en  (load_stb && en_mask[IDX]),
                .load_val (scalar_in),
                .shift_en (shift_en),
                .en_bit   (en_q[IDX]),
                .bit_idx  (bit_idx),
                .ser_in   (ser_in[IDX]),
                .ser_out  (ser_out[IDX]),
                .value    (regs_flat[IDX*W +: W])
            );
        end
    end

    mesh_reduce #(.W(W), .N(N)) u_reduce (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (reduce_stb),
        .regs_flat (regs_flat),
        .result    (scalar_out)
    );

endmodule

// File: rtl/mesh_checker.sv
module mesh_checker #(
    parameter int W = 8,
    parameter int N = 16,
    localparam int CW = $clog2(W + 2) + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_valid,
    input logic [1:0]     cmd_op,
    input logic           busy,
    input logic           done,
    input logic [W-1:0]   scalar_out,
    input logic [N*W-1:0] regs_flat
);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (busy && !done) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_shift_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == CW'(W)));

    p_shift_continues_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_idle_regs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_valid && cmd_op == 2'd1)) |=> $stable(regs_flat));

    p_scalar_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!busy && cmd_valid && cmd_op == 2'd3) |=> $stable(scalar_out));

endmodule

bind simd_mesh_top mesh_checker #(.W(W), .N(N)) u_mesh_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .busy       (busy),
    .done       (done),
    .scalar_out (scalar_out),
    .regs_flat  (regs_flat)
);

// File: tb/simd_mesh_top_bench.sv
module simd_mesh_top_bench;

    localparam int ROWS   = 4;
    localparam int COLS   = 4;
    localparam int W      = 8;
    localparam int N      = ROWS * COLS;
    localparam int PERIOD = 10;
    localparam int NVEC   = 10;

    // each entry: {direction[2:0], enable mask[15:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {3'd0, 16'hFFFF}, {3'd1, 16'hFFFF}, {3'd2, 16'hFFFF}, {3'd3, 16'hFFFF},
        {3'd4, 16'hFFFF}, {3'd5, 16'hFFFF}, {3'd6, 16'hFFFF}, {3'd7, 16'hFFFF},
        {3'd2, 16'h5A3C}, {3'd7, 16'hF00F}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [1:0]     cmd_op = 2'd0;
    logic [2:0]     cmd_dir = 3'd0;
    logic [W-1:0]   scalar_in = '0;
    logic [N-1:0]   en_mask = '0;
    logic           busy;
    logic           done;
    logic [W-1:0]   scalar_out;
    logic [N*W-1:0] regs_flat;

    int total = 0;
    int bad = 0;
    logic [W-1:0] orig [N];

    always #(PERIOD/2) clk = ~clk;

    simd_mesh_top u_simd_mesh_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dir(cmd_dir), .scalar_in(scalar_in), .en_mask(en_mask),
        .busy(busy), .done(done), .scalar_out(scalar_out), .regs_flat(regs_flat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int drow(input int d);
        if (d == 0 || d == 1 || d == 7) return -1;
        if (d == 3 || d == 4 || d == 5) return 1;
        return 0;
    endfunction

    function automatic int dcol(input int d);
        if (d == 1 || d == 2 || d == 3) return 1;
        if (d == 5 || d == 6 || d == 7) return -1;
        return 0;
    endfunction

    // starts and ends just after a falling edge
    task automatic issue(input logic [1:0] op, input logic [2:0] dir,
                         input logic [W-1:0] val, input logic [N-1:0] mask);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_dir   = dir;
        scalar_in = val;
        en_mask   = mask;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'd0;
    endtask

    task automatic preload(input int seed);
        for (int i = 0; i < N; i++) begin
            orig[i] = W'(i * 37 + seed * 11 + 5);
            issue(2'd1, 3'd0, orig[i], N'(1) << i);
        end
    endtask

    // called right after the accept edge's falling edge; waits for done
    task automatic wait_done(input int already);
        int cyc = already;
        while (!done && cyc < 4 * W) begin
            @(negedge clk);
            cyc++;
        end
        check("R6 cycles to done", cyc, W);
        @(negedge clk);
        check("R9 done pulse width", done, 0);
        check("R6 busy clear after done", busy, 0);
    endtask

    task automatic check_shift(input int dir, input logic [N-1:0] mask);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int i = r * COLS + c;
                int sr = r - drow(dir);
                int sc = c - dcol(dir);
                bit wrap = (sr < 0 || sr >= ROWS || sc < 0 || sc >= COLS);
                int s = ((sr + ROWS) % ROWS) * COLS + ((sc + COLS) % COLS);
                logic [W-1:0] exp = mask[i] ? orig[s] : orig[i];
                if (!mask[i])
                    check("R7 frozen element", regs_flat[i*W +: W], exp);
                else if (wrap)
                    check("R5 wrapped source", regs_flat[i*W +: W], exp);
                else
                    check("R4 neighbour source", regs_flat[i*W +: W], exp);
            end
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL R6 watchdog actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 regs", regs_flat == '0, 1);
        check("R1 scalar_out", scalar_out, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);

        // R2 masked broadcast
        issue(2'd1, 3'd0, 8'hA5, 16'h00FF);
        for (int i = 0; i < N; i++)
            check("R2 broadcast", regs_flat[i*W +: W], (i < 8) ? 8'hA5 : 8'h00);

        // R3 reduce
        issue(2'd3, 3'd0, 8'h00, 16'h0000);
        check("R3 reduce", scalar_out, 8'hA5);

        // table of shift vectors
        for (int k = 0; k < NVEC; k++) begin
            preload(k);
            issue(2'd2, VEC[k][18:16], 8'h00, VEC[k][15:0]);
            check("R6 busy during shift", busy, 1);
            wait_done(0);
            check_shift(int'(VEC[k][18:16]), VEC[k][15:0]);
        end

        // R3 reduce over distinct values
        preload(3);
        acc = '0;
        for (int i = 0; i < N; i++) acc |= orig[i];
        issue(2'd3, 3'd0, 8'h00, 16'h0000);
        check("R3 reduce distinct", scalar_out, acc);

        // R10 no-op and idle cycles change nothing
        issue(2'd0, 3'd3, 8'hFF, 16'hFFFF);
        repeat (2) @(negedge clk);
        for (int i = 0; i < N; i++)
            check("R10 nop regs", regs_flat[i*W +: W], orig[i]);
        check("R11 scalar held", scalar_out, acc);

        // R8 commands during a shift are ignored
        preload(7);
        issue(2'd2, 3'd4, 8'h00, 16'hFFFF);
        issue(2'd1, 3'd0, 8'hFF, 16'hFFFF);
        issue(2'd3, 3'd0, 8'h00, 16'h0000);
        issue(2'd2, 3'd0, 8'h00, 16'hFFFF);
        wait_done(3);
        check_shift(4, 16'hFFFF);
        check("R8 scalar untouched", scalar_out, acc);
        @(negedge clk);
        check("R8 no queued shift", busy, 0);

        // R1 reset in mid-shift
        issue(2'd2, 3'd2, 8'h00, 16'hFFFF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset mid-shift regs", regs_flat == '0, 1);
        check("R1 reset mid-shift busy", busy, 0);
        check("R1 reset scalar", scalar_out, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule